// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block guards a system against a stalled program. An 8-bit down counter is stepped by a tap of a 13-bit prescaler. The prescaler advances on a tick from one of two clock-enable sources, chosen by a bit in the control register. When the counter runs out, the block raises a one-cycle system reset pulse. Software keeps the system alive by feeding the block. A feed is two register writes in a row: the key A5h to the first feed address, then the key 5Ah to the second. A valid feed copies the reload shadow register into the counter and clears the prescaler.

The key sequence is strict. Once the first key has been written, the next register write must be the second key. Any other write, to any address, causes an immediate reset pulse. Idle cycles between the two writes are allowed. The block can also act as a plain interval timer. In that mode expiry sets a sticky timeout flag and reloads the counter, and no reset is raised.

Every interface pin is a plain control or status pin, so no valid/ready flow control applies. Register writes are accepted in every cycle in which the write strobe is high, and the block never stalls them.

Top module: `kwdt_top`

## Requirements
- R1: Reset state. After reset, `wd_reset` and `tmo_flag` are 0 and `cnt_q` is FFh. The control register resets to 00h, so the counter is stopped.
- R2: Valid feed. A write of A5h to address 2, followed by a write of 5Ah to address 3 as the next register write, loads `cnt_q` with the reload shadow value. The load is visible one cycle after the second write, and the prescaler is cleared. Idle cycles between the two writes are allowed.
- R3: Broken sequence. After A5h is written to address 2, any next register write other than 5Ah to address 3 pulses `wd_reset` high for one cycle. The pulse starts in the cycle after that write, in either mode and whether or not the counter runs. A 5Ah write to address 3 with no A5h before it has no effect.
- R4: Shadow reload. A write to address 1 changes only the reload shadow. `cnt_q` keeps its value until the next valid feed or timer-mode expiry.
- R5: Tick source. Control bit 2 selects the counting tick: 0 selects `per_tick` and 1 selects `osc_tick`. Pulses on the unselected input have no effect.
- R6: Timeout length. Let PRE be control bits [5:3] and RLD the reload value. In watchdog mode (control bit 1 = 0), `wd_reset` rises one cycle after the 2^(5+PRE)·(RLD+1)+1-th selected tick counted from a feed.
- R7: Timer mode. With control bit 1 = 1, expiry sets `tmo_flag`, never pulses `wd_reset`, reloads the counter from the shadow, and starts the same period again.
- R8: Flag clear. A control write (address 0) with bit 7 = 0 clears `tmo_flag`. A control write with bit 7 = 1 leaves the flag unchanged. A flag set in the same cycle wins over the clear.
- R9: Run gating. With control bit 0 = 0, ticks are ignored and `cnt_q` holds.
- R10: Stepping. `cnt_q` decreases by one every 2^(5+PRE) selected ticks while the counter runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 reload, 2 first key, 3 second key |
| bus_wdata | input | 8 | Write data |
| per_tick | input | 1 | Peripheral-clock tick enable |
| osc_tick | input | 1 | Watchdog-oscillator tick enable |
| wd_reset | output | 1 | One-cycle system reset pulse |
| tmo_flag | output | 1 | Sticky interval-timer timeout flag |
| cnt_q | output | 8 | Current down-counter value |

## Verification
The assertions check the following on every cycle:
- A broken key sequence is always followed by a reset pulse.
- A valid feed always loads the shadow value.
- The counter holds while stopped, and otherwise only steps down by one or reloads.
- The timeout flag rises only on a timer-mode expiry, and that expiry never produces a reset.

Only the bench scenarios can show the exact timeout lengths across prescale taps and reload values. The same holds for the choice of tick source, the repeat period in timer mode, and the write-one-keeps and write-zero-clears behaviour of the flag.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int ADDR_W    = 2;
  localparam int DATA_W    = 8;
  localparam int CNT_W     = 8;
  localparam int PRESC_W   = 13;
  localparam int PRE_W     = 3;
  localparam int TAP_BASE  = 5;
  localparam int NUM_TAPS  = 1 << PRE_W;

  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] A_KEY1   = 2'd2;
  localparam logic [ADDR_W-1:0] A_KEY2   = 2'd3;

  localparam logic [DATA_W-1:0] KEY1_VAL   = 8'hA5;
  localparam logic [DATA_W-1:0] KEY2_VAL   = 8'h5A;
  localparam logic [CNT_W-1:0]  RELOAD_RST = 8'hFF;

  // control byte layout: flag, spare, pre[2:0], clock select, timer mode, run
  typedef struct packed {
    logic             flag;
    logic             spare;
    logic [PRE_W-1:0] pre;
    logic             csel;
    logic             tmode;
    logic             run;
  } ctrl_t;
endpackage

// File: rtl/kwdt_feed.sv
module kwdt_feed
  import kwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed,
  output logic              feed_ok,
  output logic              feed_bad
);
  logic key1_hit, key2_hit;

  assign key1_hit = (addr == A_KEY1) && (wdata == KEY1_VAL);
  assign key2_hit = (addr == A_KEY2) && (wdata == KEY2_VAL);
  assign feed_ok  = armed && we && key2_hit;
  assign feed_bad = armed && we && !key2_hit;

  // every write while armed ends the sequence, good or bad
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  armed <= 1'b0;
    else if (we) armed <= !armed && key1_hit;
  end
endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag_set,
  output logic              run,
  output logic              tmode,
  output logic              csel,
  output logic [PRE_W-1:0]  pre,
  output logic              flag,
  output logic [CNT_W-1:0]  reload
);
  ctrl_t wr_ctrl;
  logic  ctrl_wr, reload_wr;
  logic  unused_spare;

  assign wr_ctrl      = ctrl_t'(wdata);
  assign ctrl_wr      = we && (addr == A_CTRL);
  assign reload_wr    = we && (addr == A_RELOAD);
  assign unused_spare = wr_ctrl.spare;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      tmode <= 1'b0;
      csel  <= 1'b0;
      pre   <= '0;
    end else if (ctrl_wr) begin
      run   <= wr_ctrl.run;
      tmode <= wr_ctrl.tmode;
      csel  <= wr_ctrl.csel;
      pre   <= wr_ctrl.pre;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      flag <= 1'b0;
    else if (flag_set)               flag <= 1'b1;
    else if (ctrl_wr && !wr_ctrl.flag) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload <= RELOAD_RST;
    else if (reload_wr) reload <= wdata[CNT_W-1:0];
  end
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count
  import kwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  input  logic [CNT_W-1:0] reload,
  input  logic             load,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [PRESC_W-1:0]  presc_q;
  logic [NUM_TAPS-1:0] tap_hit;
  logic                pend_q;
  logic                step;

  // one rollover detector per selectable tap
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign tap_hit[i] = &presc_q[TAP_BASE+i-1:0];
  end

  assign step   = run && tick && !load;
  assign expire = step && pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= RELOAD_RST;
      presc_q <= '0;
      pend_q  <= 1'b0;
    end else if (load || expire) begin
      cnt     <= reload;
      presc_q <= '0;
      pend_q  <= 1'b0;
    end else if (step) begin
      presc_q <= presc_q + 1'b1;
      if (tap_hit[pre]) begin
        if (cnt == '0) pend_q <= 1'b1;
        else           cnt    <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              per_tick,
  input  logic              osc_tick,
  output logic              wd_reset,
  output logic              tmo_flag,
  output logic [CNT_W-1:0]  cnt_q
);
  logic             armed, feed_ok, feed_bad;
  logic             run, tmode, csel, flag_set, expire, tick_sel;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] reload;

  kwdt_feed u_feed (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .armed(armed), .feed_ok(feed_ok), .feed_bad(feed_bad)
  );

  kwdt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .flag_set(flag_set), .run(run), .tmode(tmode), .csel(csel), .pre(pre),
    .flag(tmo_flag), .reload(reload)
  );

  assign tick_sel = csel ? osc_tick : per_tick;
  assign flag_set = expire && tmode;

  kwdt_count u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick_sel), .run(run), .pre(pre),
    .reload(reload), .load(feed_ok), .cnt(cnt_q), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wd_reset <= 1'b0;
    else        wd_reset <= feed_bad || (expire && !tmode);
  end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
  import kwdt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              wd_reset,
  input logic              tmo_flag,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              armed,
  input logic              feed_ok,
  input logic              run,
  input logic              tmode,
  input logic              expire,
  input logic [CNT_W-1:0]  reload
);
  // R3
  bad_seq_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && bus_we && !(bus_addr == A_KEY2 && bus_wdata == KEY2_VAL)) |=> wd_reset);

  // R2
  feed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |=> (cnt_q == $past(reload)));

  // R9
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !feed_ok) |=> $stable(cnt_q));

  // R10
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !feed_ok |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) - 1'b1)
                  || cnt_q == $past(reload)));

  // R7
  timer_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode && expire && !(armed && bus_we)) |=> !wd_reset);

  // R8
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $past(tmode && expire));
endmodule

bind kwdt_top kwdt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .wd_reset(wd_reset), .tmo_flag(tmo_flag),
  .cnt_q(cnt_q), .armed(armed), .feed_ok(feed_ok), .run(run),
  .tmode(tmode), .expire(expire), .reload(reload)
);

// File: tb/kwdt_top_tb.sv
module kwdt_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       per_tick = 1'b0;
  logic       osc_tick = 1'b0;
  logic       wd_reset, tmo_flag;
  logic [7:0] cnt_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kwdt_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .per_tick(per_tick), .osc_tick(osc_tick),
    .wd_reset(wd_reset), .tmo_flag(tmo_flag), .cnt_q(cnt_q)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic ticks(input bit osc, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (osc) osc_tick = 1'b1; else per_tick = 1'b1;
      @(posedge clk); #1;
    end
    @(negedge clk);
    per_tick = 1'b0; osc_tick = 1'b0;
  endtask

  task automatic feed();
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h5A);
  endtask

  // tick every cycle until reset or flag appears; n is the tick count
  task automatic measure(output int n, output bit saw_rst, output bit saw_flag);
    n = 0; saw_rst = 0; saw_flag = 0;
    while (n < 150000 && !saw_rst && !saw_flag) begin
      @(negedge clk); per_tick = 1'b1;
      @(posedge clk); #1;
      n++;
      saw_rst = wd_reset; saw_flag = tmo_flag;
    end
    @(negedge clk); per_tick = 1'b0;
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    bit r, f;
    int rl[3] = '{0, 2, 5};

    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 reset wd_reset", wd_reset, 0);
    check("R1 reset tmo_flag", tmo_flag, 0);
    check("R1 reset cnt_q", cnt_q, 255);

    ticks(0, 40);
    check("R9 stopped ticks ignored", cnt_q, 255);

    wr(2'd0, 8'h01);
    wr(2'd1, 8'h10);
    check("R4 reload write leaves cnt_q", cnt_q, 255);
    feed();
    check("R2 feed loads shadow", cnt_q, 16);
    check("R2 feed no reset", wd_reset, 0);

    ticks(0, 31);
    check("R10 31 ticks no step", cnt_q, 16);
    ticks(0, 1);
    check("R10 32nd tick steps", cnt_q, 15);

    wr(2'd0, 8'h05);
    ticks(0, 64);
    check("R5 per_tick ignored when osc selected", cnt_q, 15);
    ticks(1, 32);
    check("R5 osc_tick counts", cnt_q, 14);
    wr(2'd0, 8'h01);
    ticks(1, 64);
    check("R5 osc_tick ignored when per selected", cnt_q, 14);

    wr(2'd2, 8'hA5);
    wr(2'd0, 8'h01);
    check("R3 other write pulses reset", wd_reset, 1);
    idle(1);
    check("R3 reset pulse one cycle", wd_reset, 0);
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h5B);
    check("R3 wrong second key resets", wd_reset, 1);
    wr(2'd2, 8'hA5);
    wr(2'd2, 8'hA5);
    check("R3 repeated first key resets", wd_reset, 1);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h5A);
    check("R3 lone second key no reset", wd_reset, 0);
    check("R3 lone second key no load", cnt_q, 14);
    wr(2'd2, 8'hA5);
    idle(5);
    wr(2'd3, 8'h5A);
    check("R2 idle gap feed no reset", wd_reset, 0);
    check("R2 idle gap feed loads", cnt_q, 16);

    for (int p = 0; p < 4; p++) begin
      foreach (rl[j]) begin
        wr(2'd0, 8'((p << 3) | 1));
        wr(2'd1, 8'(rl[j]));
        feed();
        measure(n, r, f);
        check($sformatf("R6 timeout pre=%0d rld=%0d", p, rl[j]), n,
              (1 << (5 + p)) * (rl[j] + 1) + 1);
        check("R6 reset seen", r, 1);
        check("R6 no flag in watchdog mode", f, 0);
      end
    end
    wr(2'd0, 8'h39);
    wr(2'd1, 8'h00);
    feed();
    measure(n, r, f);
    check("R6 top tap timeout", n, 4097);

    wr(2'd0, 8'h03);
    wr(2'd1, 8'h01);
    feed();
    measure(n, r, f);
    check("R7 timer period", n, 65);
    check("R7 flag set", f, 1);
    check("R7 no reset", r, 0);
    check("R7 counter reloaded", cnt_q, 1);
    idle(1);
    check("R7 no reset after expiry", wd_reset, 0);
    wr(2'd0, 8'h83);
    check("R8 write one keeps flag", tmo_flag, 1);
    wr(2'd0, 8'h03);
    check("R8 write zero clears flag", tmo_flag, 0);
    measure(n, r, f);
    check("R7 repeat period", n, 65);
    check("R7 repeat flag", f, 1);
    check("R7 repeat no reset", r, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule